// File: doc/BRIEF.md
# SCL Phase Timing Generator

This block sets the pace of the clock line for an I2C master. A command engine asks it for one of three bus actions: begin a transfer, clock one bit, or end a transfer. The generator then runs the SCL low phase and the SCL high phase, counts the START hold time and the STOP or repeated-START setup time, and marks the point within each low phase at which the engine may change SDA. The engine gets a one-cycle strobe for each of these events and drives SDA itself.

Timing comes from a 32-bit word that packs four 8-bit fields: the data-valid delay in bits 31:24, the setup/hold count in bits 23:16, the high count in bits 15:8 and the low count in bits 7:0. A second word of the same layout serves high-speed transfers and is selected by `hs_sel`. A 3-bit exponent P divides the functional clock by 2^P to form the count tick. The SCL and SDA inputs each pass through a two-flop synchronizer and a glitch filter of programmable width, so the rise of SCL is confirmed on the filtered line. This also lets a target stretch the clock.

Controller states: IDLE (bus free, SCL released), HOLD (START hold, SCL high), LOW (SCL driven low), PARK (SCL held low, waiting for a request), RISE (SCL released, waiting to see it high), HIGH (SCL high phase), SETUP (STOP or repeated-START setup, SCL high). Transitions: IDLE to HOLD on a start request. HOLD to LOW when the hold count ends. LOW to PARK when the low count ends. PARK to RISE on any request, with the pending action recorded. RISE to HIGH for a bit, or RISE to SETUP for a stop or repeated start, once filtered SCL is high. HIGH to LOW when the high count ends. SETUP to IDLE for a stop, or SETUP to HOLD for a repeated start.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset `scl_out` is 1, `ready` is 1, `sda_filt` is 1 and every strobe is 0.
- R2: A `req_start` accepted in IDLE produces `hold_done` and `scl_fall` together (SETHOLD+1)·2^P clocks after the accepting edge. `scl_out` is 0 from the next cycle on.
- R3: After any `scl_fall`, `sda_change` pulses (DATAVD+1)·2^P clocks later. `ready` rises (L+1)·2^P+1 clocks after `scl_fall`, where L is bits 5:0 of the low field. Bits 7:6 of the low field have no effect.
- R4: A `req_bit` accepted while parked releases SCL. With no stretching, `scl_rise` pulses 3+Wscl clocks after the accepting edge, where Wscl is the SCL filter width.
- R5: `scl_fall` pulses (CLKHI+1)·2^P clocks after `scl_rise` for a bit.
- R6: A `req_stop` accepted while parked gives `scl_rise` (3+Wscl clocks), then `setup_done` (SETHOLD+1)·2^P clocks later. The next cycle shows `ready`=1 with `scl_out`=1.
- R7: A `req_start` accepted while parked gives `scl_rise`, then `setup_done` after (SETHOLD+1)·2^P clocks, then `hold_done` with `scl_fall` after another (SETHOLD+1)·2^P clocks.
- R8: While the external SCL line is held low after release, `scl_rise` does not occur. It follows 2+Wscl clocks after the line is let go.
- R9: The filtered output follows its synchronized input only after the input has differed from it for W consecutive clocks (W=0 passes through). A low SDA pulse of W-1 clocks leaves `sda_filt` at 1, and a lasting low reaches `sda_filt` W+2 clocks after it is applied.
- R10: With `hs_sel`=1 all counts come from `hs_timing`. With `hs_sel`=0 they come from `std_timing`.
- R11: Requests that are not valid in the current state are ignored: in IDLE, `req_bit` and `req_stop` leave `scl_out`=1, `ready`=1 and all strobes at 0.
- R12: When several requests arrive together while parked, start wins over stop, and stop wins over bit.
- R13: Every counted phase lasts N·2^P clocks for exponent P from 0 to 7, where N is the field value plus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_exp | input | 3 | Tick divider exponent P (divide by 2^P) |
| std_timing | input | 32 | Timing word for normal speeds |
| hs_timing | input | 32 | Timing word for high-speed transfers |
| hs_sel | input | 1 | Selects `hs_timing` when 1 |
| flt_scl_w | input | 4 | SCL glitch filter width in clocks |
| flt_sda_w | input | 4 | SDA glitch filter width in clocks |
| scl_in | input | 1 | Sensed SCL bus level |
| sda_in | input | 1 | Sensed SDA bus level |
| req_start | input | 1 | Start or repeated-start request, one cycle |
| req_bit | input | 1 | Clock-one-bit request, one cycle |
| req_stop | input | 1 | Stop request, one cycle |
| ready | output | 1 | High in IDLE and PARK |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_filt | output | 1 | Synchronized and filtered SDA |
| setup_done | output | 1 | Stop / repeated-start setup finished |
| hold_done | output | 1 | START hold finished |
| scl_rise | output | 1 | Filtered SCL seen high after release |
| scl_fall | output | 1 | SCL about to be driven low |
| sda_change | output | 1 | Point in the low phase to change SDA |

## Verification
The assertions check, on every cycle, the relations between the strobes and the line: a hold end always comes with a fall, a fall is always followed by SCL driven low, SDA-change and setup strobes fall only in the low and high line states respectively, the tick never fires on two consecutive cycles with a stable divider, and the filter output only takes values its synchronized input has held. Only the bench scenarios can show the exact durations in clocks for each field and exponent, the choice of timing word, clock stretching, filter rejection of short pulses, and the request priority and ignore rules.

// File: rtl/scl_tmg_pkg.sv
package scl_tmg_pkg;

    localparam int FLD_W   = 8;
    localparam int LO_USED = 6;

    // Field order is fixed: software packs the word this way.
    typedef struct packed {
        logic [FLD_W-1:0] dvalid;
        logic [FLD_W-1:0] shold;
        logic [FLD_W-1:0] hi;
        logic [FLD_W-1:0] lo;
    } phase_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LOW,
        PH_PARK,
        PH_RISE,
        PH_HIGH,
        PH_SETUP
    } phase_e;

    typedef enum logic [1:0] {
        NX_BIT,
        NX_STOP,
        NX_RSTART
    } nxt_op_e;

endpackage

// File: rtl/scl_presc.sv
module scl_presc #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_i,
    input  logic             clr,
    output logic             tick
);
    localparam int CW = (1 << EXP_W) - 1;

    logic [CW-1:0] pc;
    logic [CW-1:0] mask;

    assign mask = CW'((32'd1 << exp_i) - 32'd1);
    assign tick = (pc == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pc <= '0;
        else if (clr || tick) pc <= '0;
        else                  pc <= pc + 1'b1;
    end

    // R13
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mask != '0) |=> (!tick || !$stable(mask)));

endmodule

// File: rtl/scl_glitch_flt.sv
module scl_glitch_flt #(
    parameter int WID_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WID_W-1:0] width,
    input  logic             din,
    output logic             dout
);
    logic [SYNC_N-1:0] sy;
    logic              s;
    logic              q;
    logic [WID_W-1:0]  cnt;

    assign s = sy[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy <= '1;
        else        sy <= {sy[SYNC_N-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= 1'b1;
            cnt <= '0;
        end else if (s == q || width == '0) begin
            q   <= s;
            cnt <= '0;
        end else if (cnt == width - 1'b1) begin
            q   <= s;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign dout = (width == '0) ? s : q;

    // R9
    flt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q != $past(q)) |-> (q == $past(s)));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_tmg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_cfg_t cfg,
    input  logic       tick,
    input  logic       scl_hi,
    input  logic       req_start,
    input  logic       req_bit,
    input  logic       req_stop,
    output logic       clr,
    output logic       ready,
    output logic       scl_out,
    output logic       setup_done,
    output logic       hold_done,
    output logic       scl_rise,
    output logic       scl_fall,
    output logic       sda_change
);
    localparam logic [FLD_W-1:0] LO_MASK = FLD_W'((1 << LO_USED) - 1);

    phase_e           state, state_n;
    nxt_op_e          op, op_n;
    logic [FLD_W-1:0] cnt;
    logic [FLD_W-1:0] lim;
    logic [FLD_W-1:0] lo_eff;
    logic             last;

    assign lo_eff = cfg.lo & LO_MASK;

    always_comb begin
        unique case (state)
            PH_HOLD, PH_SETUP: lim = cfg.shold;
            PH_LOW:            lim = lo_eff;
            PH_HIGH:           lim = cfg.hi;
            default:           lim = '0;
        endcase
    end

    assign last = tick && (cnt == lim);
    assign clr  = (state_n != state);

    // next state
    always_comb begin
        state_n = state;
        op_n    = op;
        unique case (state)
            PH_IDLE:  if (req_start) state_n = PH_HOLD;
            PH_HOLD:  if (last) state_n = PH_LOW;
            PH_LOW:   if (last) state_n = PH_PARK;
            PH_PARK: begin
                if (req_start) begin
                    state_n = PH_RISE;
                    op_n    = NX_RSTART;
                end else if (req_stop) begin
                    state_n = PH_RISE;
                    op_n    = NX_STOP;
                end else if (req_bit) begin
                    state_n = PH_RISE;
                    op_n    = NX_BIT;
                end
            end
            PH_RISE:  if (scl_hi) state_n = (op == NX_BIT) ? PH_HIGH : PH_SETUP;
            PH_HIGH:  if (last) state_n = PH_LOW;
            PH_SETUP: if (last) state_n = (op == NX_STOP) ? PH_IDLE : PH_HOLD;
            default:  state_n = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            op    <= NX_BIT;
            cnt   <= '0;
        end else begin
            state <= state_n;
            op    <= op_n;
            if (state_n != state) cnt <= '0;
            else if (tick)        cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_out <= 1'b1;
        else        scl_out <= !(state_n == PH_LOW || state_n == PH_PARK);
    end

    always_comb begin
        ready      = (state == PH_IDLE) || (state == PH_PARK);
        hold_done  = (state == PH_HOLD) && last;
        setup_done = (state == PH_SETUP) && last;
        scl_rise   = (state == PH_RISE) && scl_hi;
        scl_fall   = ((state == PH_HOLD) || (state == PH_HIGH)) && last;
        sda_change = (state == PH_LOW) && tick && (cnt == cfg.dvalid);
    end

    // R2
    hold_with_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |-> scl_fall);
    // R5
    fall_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> !scl_out);
    // R3
    sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> !scl_out);
    // R4
    rise_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> scl_out);
    // R6
    setup_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |-> scl_out);

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import scl_tmg_pkg::*;
#(
    parameter int EXP_W  = 3,
    parameter int FLT_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] presc_exp,
    input  logic [31:0]      std_timing,
    input  logic [31:0]      hs_timing,
    input  logic             hs_sel,
    input  logic [FLT_W-1:0] flt_scl_w,
    input  logic [FLT_W-1:0] flt_sda_w,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             req_start,
    input  logic             req_bit,
    input  logic             req_stop,
    output logic             ready,
    output logic             scl_out,
    output logic             sda_filt,
    output logic             setup_done,
    output logic             hold_done,
    output logic             scl_rise,
    output logic             scl_fall,
    output logic             sda_change
);
    localparam int N_LINES = 2;

    phase_cfg_t       cfg;
    logic             tick;
    logic             clr;
    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] clean;
    logic [FLT_W-1:0] fw [N_LINES];

    assign cfg    = hs_sel ? phase_cfg_t'(hs_timing) : phase_cfg_t'(std_timing);
    assign raw[0] = scl_in;
    assign raw[1] = sda_in;
    assign fw[0]  = flt_scl_w;
    assign fw[1]  = flt_sda_w;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        scl_glitch_flt #(.WID_W(FLT_W), .SYNC_N(SYNC_N)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .width (fw[g]),
            .din   (raw[g]),
            .dout  (clean[g])
        );
    end

    assign sda_filt = clean[1];

    scl_presc #(.EXP_W(EXP_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .exp_i (presc_exp),
        .clr   (clr),
        .tick  (tick)
    );

    scl_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .tick       (tick),
        .scl_hi     (clean[0]),
        .req_start  (req_start),
        .req_bit    (req_bit),
        .req_stop   (req_stop),
        .clr        (clr),
        .ready      (ready),
        .scl_out    (scl_out),
        .setup_done (setup_done),
        .hold_done  (hold_done),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_change (sda_change)
    );

endmodule

// File: tb/tb_i2c_scl_timer.sv
module tb_i2c_scl_timer;

    localparam int LIM = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  presc_exp = '0;
    logic [31:0] std_timing = '0;
    logic [31:0] hs_timing = '0;
    logic        hs_sel = 1'b0;
    logic [3:0]  flt_scl_w = '0;
    logic [3:0]  flt_sda_w = '0;
    logic        stretch = 1'b0;
    logic        sda_in = 1'b1;
    logic        req_start = 1'b0, req_bit = 1'b0, req_stop = 1'b0;
    logic        scl_in;
    logic        ready, scl_out, sda_filt, setup_done, hold_done;
    logic        scl_rise, scl_fall, sda_change;

    int checks = 0;
    int errors = 0;

    // active configuration as seen by the bench
    int p, lo6, lotop, hi, sh, dv, w;

    always #10 clk = ~clk;

    assign scl_in = scl_out & ~stretch;

    i2c_scl_timer dut (
        .clk(clk), .rst_n(rst_n), .presc_exp(presc_exp),
        .std_timing(std_timing), .hs_timing(hs_timing), .hs_sel(hs_sel),
        .flt_scl_w(flt_scl_w), .flt_sda_w(flt_sda_w),
        .scl_in(scl_in), .sda_in(sda_in),
        .req_start(req_start), .req_bit(req_bit), .req_stop(req_stop),
        .ready(ready), .scl_out(scl_out), .sda_filt(sda_filt),
        .setup_done(setup_done), .hold_done(hold_done),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_change(sda_change)
    );

    function automatic logic sig(input int k);
        case (k)
            0: return hold_done;
            1: return setup_done;
            2: return scl_rise;
            3: return scl_fall;
            4: return sda_change;
            5: return ready;
            default: return !sda_filt;
        endcase
    endfunction

    function automatic int ph(input int f);
        return (f + 1) << p;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_now(input int k, input int start, output int n);
        n = start;
        while (!sig(k) && n < LIM) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic step_wait(input int k, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sig(k) && n < LIM);
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk);
        {req_start, req_bit, req_stop} = m;
        @(negedge clk);
        {req_start, req_bit, req_stop} = 3'b000;
    endtask

    task automatic apply_cfg(input bit use_hs);
        logic [31:0] word;
        word = {dv[7:0], sh[7:0], hi[7:0], lotop[1:0], lo6[5:0]};
        presc_exp = p[2:0];
        flt_scl_w = w[3:0];
        hs_sel    = use_hs;
        if (use_hs) begin
            hs_timing  = word;
            std_timing = 32'h3F3F3F3F;
        end else begin
            std_timing = word;
            hs_timing  = 32'h3F3F3F3F;
        end
    endtask

    task automatic low_phase(input string tag);
        int n;
        step_wait(4, n);
        chk(n, ph(dv), {tag, " R3 sda_change delay"});
        step_wait(5, n);
        chk(n, ph(lo6) + 1 - ph(dv), {tag, " R3 low length"});
    endtask

    task automatic do_start(input string tag);
        int n;
        pulse(3'b100);
        wait_now(0, 1, n);
        chk(n, ph(sh), {tag, " R2 start hold"});
        chk(int'(scl_fall), 1, {tag, " R2 fall with hold"});
        low_phase(tag);
    endtask

    task automatic do_bit(input string tag);
        int n;
        pulse(3'b010);
        wait_now(2, 1, n);
        chk(n, 3 + w, {tag, " R4 rise latency"});
        step_wait(3, n);
        chk(n, ph(hi), {tag, " R5 high length"});
        low_phase(tag);
    endtask

    task automatic do_stop(input string tag, input logic [2:0] m);
        int n;
        pulse(m);
        wait_now(2, 1, n);
        chk(n, 3 + w, {tag, " R6 stop rise"});
        step_wait(1, n);
        chk(n, ph(sh), {tag, " R6 stop setup"});
        @(negedge clk);
        chk(int'(ready && scl_out), 1, {tag, " R6 back to idle"});
    endtask

    task automatic do_rstart(input string tag, input logic [2:0] m);
        int n;
        pulse(m);
        wait_now(2, 1, n);
        chk(n, 3 + w, {tag, " R7 rstart rise"});
        step_wait(1, n);
        chk(n, ph(sh), {tag, " R7 rstart setup"});
        step_wait(0, n);
        chk(n, ph(sh), {tag, " R7 rstart hold"});
        low_phase(tag);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int n;
        bit ok;
        void'($urandom(32'd7741));
        p = 0; lo6 = 5; lotop = 0; hi = 2; sh = 2; dv = 1; w = 0;
        apply_cfg(0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(int'({ready, scl_out, sda_filt}), 7, "R1 reset outputs");
        chk(int'({setup_done, hold_done, scl_rise, scl_fall, sda_change}), 0, "R1 reset strobes");

        // basic frame
        do_start("d1");
        do_bit("d1");
        do_bit("d1");
        do_stop("d1", 3'b001);

        // prescaled, low-field upper bits set, filter on SCL
        p = 2; lo6 = 3; lotop = 3; hi = 1; sh = 0; dv = 0; w = 2;
        apply_cfg(0);
        do_start("d2");
        do_bit("d2");
        do_rstart("d2", 3'b100);
        do_bit("d2");
        do_stop("d2", 3'b001);

        // R12 priority
        p = 0; lo6 = 4; lotop = 0; hi = 3; sh = 1; dv = 2; w = 0;
        apply_cfg(0);
        do_start("R12");
        do_rstart("R12 start over stop", 3'b101);
        do_stop("R12 stop over bit", 3'b011);

        // R10 high-speed word
        p = 1; lo6 = 2; lotop = 1; hi = 0; sh = 4; dv = 1; w = 1;
        apply_cfg(1);
        do_start("R10 hs");
        do_bit("R10 hs");
        do_stop("R10 hs", 3'b001);

        // R13 largest exponent
        p = 7; lo6 = 0; lotop = 0; hi = 0; sh = 1; dv = 0; w = 0;
        apply_cfg(0);
        do_start("R13 p7");
        do_stop("R13 p7", 3'b001);

        // R8 clock stretching
        p = 0; lo6 = 2; lotop = 0; hi = 1; sh = 1; dv = 0; w = 0;
        apply_cfg(0);
        do_start("R8");
        stretch = 1'b1;
        pulse(3'b010);
        ok = 1;
        for (int i = 2; i <= 20; i++) begin
            if (scl_rise) ok = 0;
            @(negedge clk);
        end
        chk(int'(ok), 1, "R8 no rise while held low");
        stretch = 1'b0;
        wait_now(2, 20, n);
        chk(n, 22, "R8 rise after release");
        step_wait(3, n);
        chk(n, ph(hi), "R8 high length");
        low_phase("R8");
        do_stop("R8", 3'b001);

        // R11 requests ignored in IDLE
        pulse(3'b011);
        ok = 1;
        for (int i = 0; i < 12; i++) begin
            if (!(ready && scl_out) || setup_done || hold_done || scl_rise ||
                scl_fall || sda_change) ok = 0;
            @(negedge clk);
        end
        chk(int'(ok), 1, "R11 bit/stop ignored in idle");

        // R9 SDA glitch filter
        flt_sda_w = 4'd4;
        repeat (3) @(negedge clk);
        ok = 1;
        sda_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!sda_filt) ok = 0;
        end
        sda_in = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!sda_filt) ok = 0;
        end
        chk(int'(ok), 1, "R9 short pulse rejected");
        sda_in = 1'b0;
        step_wait(6, n);
        chk(n, 6, "R9 lasting low latency");
        sda_in = 1'b1;
        repeat (10) @(negedge clk);
        chk(int'(sda_filt), 1, "R9 filter returns high");

        // constrained random frames
        for (int t = 0; t < 25; t++) begin
            int nb;
            p     = $urandom_range(0, 3);
            lo6   = $urandom_range(0, 15);
            lotop = $urandom_range(0, 3);
            hi    = $urandom_range(0, 10);
            sh    = $urandom_range(0, 10);
            dv    = $urandom_range(0, lo6);
            w     = $urandom_range(0, 5);
            apply_cfg($urandom_range(0, 1) == 1);
            do_start("rnd");
            nb = $urandom_range(1, 3);
            for (int b = 0; b < nb; b++) begin
                if ($urandom_range(0, 3) == 0) do_rstart("rnd", 3'b100);
                do_bit("rnd");
            end
            do_stop("rnd", 3'b001);
        end

        summary();
        $finish;
    end

endmodule